// File: doc/BRIEF.md
# Handshake Pipeline FIFO Controller

A chain of storage stages that moves data words from a producer to a consumer using four-phase request/acknowledge handshakes instead of shared read and write pointers. Each stage owns one control bit, a clocked model of a Muller C-element. That bit combines the request arriving from the stage upstream with the inverse of the control bit of the stage downstream. When the control bit rises, the stage captures the word held by its upstream neighbour. The same bit acknowledges the upstream stage and requests the downstream one.

The block is a clocked model of a self-timed pipeline. The producer raises `rin_i` with a stable word on `data_i`. It may drop the word once `ain_o` rises, and it then returns `rin_i` to zero. The consumer sees `rout_o` rise with the word on `data_o`, raises `aout_i`, and lowers it again once `rout_o` falls. The settling time of the logic between stages is modelled by a delay of `MATCH_DLY` clock cycles on each forward request. A value of zero gives a plain handshake FIFO.

Top module: `mp_fifo_ctrl`

## Requirements
- R1: While `rst_ni` is low, every control bit is 0. `ain_o`, `rout_o` and `data_o` read 0 and the pipeline holds no word.
- R2: A stage's control bit takes the common value of its two inputs (upstream request, inverted downstream control) when they agree. It keeps its previous value when they differ.
- R3: `ain_o` rises only on an edge that saw `rin_i` high, and falls only on an edge that saw `rin_i` low.
- R4: `rout_o` rises only on an edge that saw `aout_i` low, and falls only on an edge that saw `aout_i` high.
- R5: Words leave on `data_o` in the order they were accepted, with the value `data_i` had when `ain_o` rose. `data_i` may change freely once `ain_o` is high.
- R6: With the pipeline empty and `aout_i` low, `rout_o` rises exactly 1 + (NUM_STAGES-1)*(MATCH_DLY+1) clock edges after the first edge that sees `rin_i` high.
- R7: With `aout_i` held low, the pipeline acknowledges exactly ceil(NUM_STAGES/2) words. The next request stays unacknowledged until the consumer takes a word.
- R8: A stage's stored word changes only on the edge where its control bit rises. So `data_o` is stable for as long as `rout_o` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rin_i | input | 1 | Producer request |
| ain_o | output | 1 | Acknowledge to producer (control bit of stage 0) |
| data_i | input | DATA_W | Producer word, stable from `rin_i` rising until `ain_o` rises |
| rout_o | output | 1 | Request to consumer (control bit of last stage) |
| aout_i | input | 1 | Consumer acknowledge |
| data_o | output | DATA_W | Word held by the last stage |

## Verification
The bench replaces `data_i` with garbage as soon as `ain_o` rises. A stage that kept its latch open while its control bit was high, instead of capturing on the rising edge, would then deliver that garbage. The bench holds the consumer off to fill the chain and counts the acknowledged words. A chain that let adjacent stages be full together would take too many words, and one with a wrong acknowledge polarity would lock up on the first word. The bench times a single word through the empty chain to catch a delay line that is one cycle short or long. Throughout the run, the bench watches both handshakes for an edge that breaks the four-phase order.

// File: rtl/mp_pkg.sv
package mp_pkg;

  // Muller C-element next state: follow when inputs agree, hold otherwise
  function automatic logic c_next(input logic a, input logic b, input logic c);
    return (a == b) ? a : c;
  endfunction

  function automatic int unsigned empty_latency(input int unsigned stages,
                                                input int unsigned dly);
    return 1 + (stages - 1) * (dly + 1);
  endfunction

endpackage

// File: rtl/mp_c_elem.sv
module mp_c_elem (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  output logic c_o,
  output logic rise_o
);
  import mp_pkg::*;

  logic c_d;

  assign c_d    = c_next(a_i, b_i, c_o);
  assign rise_o = c_d & ~c_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) c_o <= 1'b0;
    else         c_o <= c_d;
  end

  // R2
  c_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i != b_i) |=> $stable(c_o));

  // R2
  c_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i == b_i) |=> (c_o == $past(a_i)));

endmodule

// File: rtl/mp_delay_line.sv
module mp_delay_line #(
  parameter int unsigned DLY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic out_o
);

  if (DLY == 0) begin : g_wire
    assign out_o = in_i;
  end else begin : g_reg
    logic [DLY-1:0] sr_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sr_q <= '0;
      end else begin
        sr_q[0] <= in_i;
        for (int k = 1; k < int'(DLY); k++) sr_q[k] <= sr_q[k-1];
      end
    end

    assign out_o = sr_q[DLY-1];
  end

endmodule

// File: rtl/mp_stage.sv
module mp_stage #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              ack_n_i,
  input  logic [DATA_W-1:0] d_i,
  output logic              ctl_o,
  output logic [DATA_W-1:0] q_o
);

  logic cap;

  mp_c_elem u_c (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (req_i),
    .b_i    (ack_n_i),
    .c_o    (ctl_o),
    .rise_o (cap)
  );

  // capture on the control rise; upstream word is held until we drop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  q_o <= '0;
    else if (cap) q_o <= d_i;
  end

  // R8
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(q_o) |-> $rose(ctl_o));

endmodule

// File: rtl/mp_fifo_ctrl.sv
module mp_fifo_ctrl #(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned MATCH_DLY  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rin_i,
  output logic              ain_o,
  input  logic [DATA_W-1:0] data_i,
  output logic              rout_o,
  input  logic              aout_i,
  output logic [DATA_W-1:0] data_o
);

  localparam int unsigned LAST = NUM_STAGES - 1;

  logic [NUM_STAGES-1:0] ctl;
  logic [NUM_STAGES-1:0] req;
  logic [NUM_STAGES-1:0] ack_n;
  logic [DATA_W-1:0]     q   [NUM_STAGES];
  logic [DATA_W-1:0]     src [NUM_STAGES];

  for (genvar i = 0; i < int'(NUM_STAGES); i++) begin : g_stage
    if (i == 0) begin : g_head
      assign req[i] = rin_i;
      assign src[i] = data_i;
    end else begin : g_body
      mp_delay_line #(.DLY(MATCH_DLY)) u_dly (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .in_i   (ctl[i-1]),
        .out_o  (req[i])
      );
      assign src[i] = q[i-1];
    end

    if (i == int'(LAST)) begin : g_tail
      assign ack_n[i] = ~aout_i;
    end else begin : g_mid
      assign ack_n[i] = ~ctl[i+1];
    end

    mp_stage #(.DATA_W(DATA_W)) u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (req[i]),
      .ack_n_i (ack_n[i]),
      .d_i     (src[i]),
      .ctl_o   (ctl[i]),
      .q_o     (q[i])
    );
  end

  assign ain_o  = ctl[0];
  assign rout_o = ctl[LAST];
  assign data_o = q[LAST];

  // R3
  ain_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ain_o) |-> $past(rin_i));

  // R3
  ain_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ain_o) |-> !$past(rin_i));

  // R4
  rout_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rout_o) |-> !$past(aout_i));

  // R4
  rout_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rout_o) |-> $past(aout_i));

endmodule

// File: tb/mp_fifo_ctrl_bench.sv
module mp_fifo_ctrl_bench;
  localparam int N = 4;
  localparam int W = 16;
  localparam int D = 2;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         rin_i = 1'b0;
  logic         aout_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic         ain_o, rout_o;
  logic [W-1:0] data_o;

  always #4 clk_i = ~clk_i;

  mp_fifo_ctrl #(.NUM_STAGES(N), .DATA_W(W), .MATCH_DLY(D)) u_mp_fifo_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .rin_i(rin_i), .ain_o(ain_o),
    .data_i(data_i), .rout_o(rout_o), .aout_i(aout_i), .data_o(data_o)
  );

  int n_chk = 0, n_fail = 0;
  int in_err = 0, out_err = 0, hold_err = 0;
  bit cons_en = 1'b0;
  bit done = 1'b0;
  logic [W-1:0] exp_q[$];

  function automatic int exp_latency();
    return 1 + (N - 1) * (D + 1);
  endfunction

  function automatic int exp_capacity();
    return (N + 1) / 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  // handshake order monitor (R3, R4)
  logic rin_p = 1'b0, ain_p = 1'b0, aout_p = 1'b0, rout_p = 1'b0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (ain_o !== ain_p && ain_o !== rin_p) in_err++;
      if (rout_o !== rout_p && rout_o === aout_p) out_err++;
    end
    rin_p = rin_i; ain_p = ain_o; aout_p = aout_i; rout_p = rout_o;
  end

  // consumer with random acknowledge delay
  initial begin
    forever begin
      @(negedge clk_i);
      if (cons_en && rout_o) begin
        logic [W-1:0] got;
        logic [W-1:0] want;
        got = data_o;
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected word", int'(got), 0);
        end else begin
          want = exp_q.pop_front();
          check(got == want, "R5 data order", int'(got), int'(want));
        end
        for (int k = 0; k < int'($urandom_range(3, 0)); k++) begin
          @(negedge clk_i);
          if (data_o !== got) hold_err++;
        end
        @(posedge clk_i); #1 aout_i = 1'b1;
        do @(negedge clk_i); while (rout_o);
        @(posedge clk_i); #1 aout_i = 1'b0;
      end
    end
  end

  task automatic finish_push(input logic [W-1:0] d);
    while (!ain_o) @(negedge clk_i);
    exp_q.push_back(d);
    @(posedge clk_i); #1 rin_i = 1'b0;
    data_i = W'($urandom);            // R5: input word dropped after acknowledge
    do @(negedge clk_i); while (ain_o);
  endtask

  task automatic push(input logic [W-1:0] d, input int tmo, output bit acked);
    @(posedge clk_i); #1 data_i = d; rin_i = 1'b1;
    acked = 1'b0;
    for (int k = 0; k < tmo; k++) begin
      @(negedge clk_i);
      if (ain_o) begin acked = 1'b1; break; end
    end
    if (acked) finish_push(d);
  endtask

  task automatic drain();
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk_i);
      if (exp_q.size() == 0 && !rout_o && !aout_i) break;
    end
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    bit acked;
    int lat, cnt;
    logic [W-1:0] first_w, pend_w;
    void'($urandom(32'h1357_9bdf));

    repeat (3) @(negedge clk_i);
    // R1
    check(ain_o == 1'b0, "R1 ain reset", int'(ain_o), 0);
    check(rout_o == 1'b0, "R1 rout reset", int'(rout_o), 0);
    check(data_o == '0, "R1 data reset", int'(data_o), 0);
    @(posedge clk_i); #1 rst_ni = 1'b1;
    cons_en = 1'b1;

    // R6: single word through empty chain
    lat = 0;
    fork
      push(16'hA5C3, 200, acked);
      begin
        @(posedge clk_i); #1;
        forever begin
          @(negedge clk_i);
          if (rout_o) break;
          lat++;
        end
      end
    join
    check(lat == exp_latency(), "R6 empty latency", lat, exp_latency());
    drain();

    // R7: stall consumer and fill
    cons_en = 1'b0;
    cnt = 0;
    first_w = 16'h1111;
    pend_w = '0;
    for (int k = 0; k < N + 2; k++) begin
      logic [W-1:0] w;
      w = W'(16'h1111 * (k + 1));
      push(w, 60, acked);
      if (!acked) begin pend_w = w; break; end
      cnt++;
    end
    check(cnt == exp_capacity(), "R7 stalled capacity", cnt, exp_capacity());
    check(ain_o == 1'b0, "R7 extra request unacknowledged", int'(ain_o), 0);
    check(rout_o == 1'b1, "R8 rout held while stalled", int'(rout_o), 1);
    check(data_o == first_w, "R8 output word held", int'(data_o), int'(first_w));
    cons_en = 1'b1;
    finish_push(pend_w);
    drain();

    // R5: random traffic
    for (int k = 0; k < 200; k++) begin
      repeat ($urandom_range(4, 0)) @(posedge clk_i);
      push(W'($urandom), 500, acked);
      if (!acked) check(1'b0, "R5 producer stuck", 0, 1);
    end
    drain();
    check(exp_q.size() == 0, "R5 all words delivered", exp_q.size(), 0);

    // back-to-back corner values
    push('0, 500, acked);
    push('1, 500, acked);
    push(16'h8001, 500, acked);
    drain();
    check(exp_q.size() == 0, "R5 corner words delivered", exp_q.size(), 0);

    check(in_err == 0, "R3 input handshake order", in_err, 0);
    check(out_err == 0, "R4 output handshake order", out_err, 0);
    check(hold_err == 0, "R8 data_o stable while rout_o high", hold_err, 0);
    report();
  end

endmodule